// File: doc/BRIEF.md
# Configurable Serial Transmitter with Transmit Buffer

This block is the send half of an asynchronous serial port whose line format is chosen at run time. A bus-side write strobe pushes bytes into a four-entry first-in first-out buffer. A shift engine takes the oldest byte and puts it on the line as one frame. Each frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. A single-cycle `baud_tick` pulse from outside sets the bit timing. Each bit lasts `TICKS_PER_BIT` ticks.

The host sees four status outputs. `buf_empty` means every buffered byte has moved into the shifter. `buf_full` means the buffer holds four bytes. `tx_busy` means some byte is still waiting or still on the line. `irq` is the empty condition gated by an enable input. The line settings are sampled when a byte moves into the shifter. They should only change while `tx_busy` is low.

Top module: `sertx_fifo`

## Requirements
- R1: `cfg_len` selects the number of data bits as 8 minus its value: code 0 gives 8 bits, 1 gives 7, 2 gives 6 and 3 gives 5. Data bits go out least significant first, right after the start bit.
- R2: When `cfg_par_off` is 1, no parity bit is sent. When it is 0, a parity bit follows the data bits. That bit is the XOR of the configured data bits only, inverted when `cfg_par_odd` is 1. So both clear gives even parity, and `cfg_par_odd` set gives odd parity.
- R3: `cfg_one_stop` set sends one high stop bit; clear sends two.
- R4: The buffer holds 4 bytes. `buf_full` is 1 exactly when 4 bytes are waiting, and `buf_empty` and `buf_full` are never both 1.
- R5: A write while `buf_full` is 1 is discarded. The buffered bytes and their order are unchanged, and the discarded byte never appears on the line.
- R6: `buf_empty` is 1 after reset. A write clears it on the next clock edge. It becomes 1 again on the edge at which the last buffered byte moves into the shifter, even if that byte is still being sent.
- R7: `tx_busy` rises on the edge after a write is accepted. It stays high while bytes are waiting or a frame is on the line, including its last stop bit, and falls on the edge that ends the last stop bit of the last byte.
- R8: `irq` equals `buf_empty` when `irq_en` is 1 and is 0 when `irq_en` is 0.
- R9: `txd` is 1 after reset and between frames. When the shifter is idle, a waiting byte is loaded on the next clock edge. The start bit begins on the edge of the first `baud_tick` after that load, and every bit lasts 16 `baud_tick` pulses.
- R10: Bytes leave the line in the order they were written, with no byte repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Push `wr_data` into the buffer this cycle |
| wr_data | input | 8 | Byte to send |
| cfg_len | input | 2 | Data length code, bits = 8 - code |
| cfg_par_off | input | 1 | 1 = no parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_one_stop | input | 1 | 1 = one stop bit, 0 = two |
| irq_en | input | 1 | Enables the buffer-empty request |
| baud_tick | input | 1 | One pulse per sub-bit time unit |
| txd | output | 1 | Serial line, idles high |
| buf_empty | output | 1 | No byte waiting in the buffer |
| buf_full | output | 1 | Buffer holds 4 bytes |
| tx_busy | output | 1 | A byte is waiting or on the line |
| irq | output | 1 | Buffer-empty request |

## Verification
With a tick on every cycle, an accepted write on edge E0 loads the shifter at E1, and the start bit drives `txd` low from E2. Bit k therefore occupies edges E2+16k to E2+16(k+1). Each frame check waits for that low level and samples every bit 8 ticks into its window, on the falling clock edge. The same count puts the fall of `tx_busy` exactly after edge E2+16·n for an n-bit frame. The bench checks the level one cycle before and one cycle after that edge, which separates one stop bit from two. Buffer flags are read on the falling edge after the write that should change them. For example, `buf_full` is read right after the fifth back-to-back write.

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH         = 4,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_off,
  input  logic       cfg_par_odd,
  input  logic       cfg_one_stop,
  input  logic       irq_en,
  input  logic       baud_tick,
  output logic       txd,
  output logic       buf_empty,
  output logic       buf_full,
  output logic       tx_busy,
  output logic       irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int FW = 12;
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
  localparam logic [TW-1:0] LAST_TICK = TW'(TICKS_PER_BIT - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          loaded, running;
  logic [FW-1:0] sh, frame;
  logic [3:0]    bits_left, nbits, ndata;
  logic [TW-1:0] tcnt;

  wire push = wr_en && !buf_full;
  wire pop  = !loaded && !running && (cnt != '0);

  assign buf_full  = (cnt == CW'(DEPTH));
  assign buf_empty = (cnt == '0);
  assign tx_busy   = !buf_empty || loaded || running;
  assign irq       = irq_en && buf_empty;
  assign ndata     = 4'd8 - {2'b00, cfg_len};
  assign nbits     = 4'd2 + ndata + {3'b000, !cfg_par_off} + {3'b000, !cfg_one_stop};

  always_comb begin
    logic par;
    par   = cfg_par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(ndata)) begin
        frame[i+1] = mem[rd_ptr][i];
        par = par ^ mem[rd_ptr][i];
      end
    end
    if (!cfg_par_off) frame[ndata+1] = par;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded    <= 1'b0;
      running   <= 1'b0;
      sh        <= '1;
      bits_left <= '0;
      tcnt      <= '0;
      txd       <= 1'b1;
    end else if (pop) begin
      sh        <= frame;
      bits_left <= nbits;
      loaded    <= 1'b1;
    end else if (baud_tick) begin
      if (loaded) begin
        loaded  <= 1'b0;
        running <= 1'b1;
        tcnt    <= '0;
        txd     <= sh[0];
      end else if (running) begin
        if (tcnt == LAST_TICK) begin
          tcnt <= '0;
          if (bits_left == 4'd1) begin
            running <= 1'b0;
            txd     <= 1'b1;
          end else begin
            sh        <= {1'b1, sh[FW-1:1]};
            bits_left <= bits_left - 1'b1;
            txd       <= sh[1];
          end
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sertx_fifo_chk.sv
module sertx_fifo_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          txd,
  input logic          buf_empty,
  input logic          buf_full,
  input logic          tx_busy,
  input logic          irq,
  input logic          irq_en,
  input logic [CW-1:0] cnt
);
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_empty, buf_full}));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |=> (cnt == CW'(DEPTH) || cnt == CW'(DEPTH - 1)));

  a_r6_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !buf_full) |=> !buf_empty);

  a_r7_end_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> (buf_empty && txd));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && buf_empty));

  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
endmodule

bind sertx_fifo sertx_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .txd(txd),
  .buf_empty(buf_empty), .buf_full(buf_full), .tx_busy(tx_busy),
  .irq(irq), .irq_en(irq_en), .cnt(cnt)
);

// File: tb/sertx_fifo_tb_top.sv
module sertx_fifo_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_len = '0;
  logic cfg_par_off = 1'b0, cfg_par_odd = 1'b0, cfg_one_stop = 1'b0;
  logic irq_en = 1'b0, baud_tick = 1'b0;
  logic txd, buf_empty, buf_full, tx_busy, irq;

  int total = 0, bad = 0, tp = 1, tick_ctr = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sertx_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_len(cfg_len), .cfg_par_off(cfg_par_off), .cfg_par_odd(cfg_par_odd),
    .cfg_one_stop(cfg_one_stop), .irq_en(irq_en), .baud_tick(baud_tick),
    .txd(txd), .buf_empty(buf_empty), .buf_full(buf_full),
    .tx_busy(tx_busy), .irq(irq)
  );

  always @(negedge clk) begin
    baud_tick <= (tick_ctr == 0);
    tick_ctr  <= (tick_ctr + 1 >= tp) ? 0 : tick_ctr + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_nb(input logic [1:0] len, input bit poff, input bit one);
    return 1 + (8 - int'(len)) + (poff ? 0 : 1) + (one ? 1 : 2);
  endfunction

  function automatic logic [11:0] exp_bits(input logic [7:0] d, input logic [1:0] len,
                                           input bit poff, input bit odd);
    logic [11:0] f;
    int n;
    bit p;
    n = 8 - int'(len);
    f = '1;
    f[0] = 1'b0;
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      f[i+1] = d[i];
      p = p ^ d[i];
    end
    if (!poff) f[n+1] = odd ? ~p : p;
    return f;
  endfunction

  task automatic set_cfg(input logic [1:0] len, input bit poff, input bit odd, input bit one);
    @(negedge clk);
    cfg_len = len; cfg_par_off = poff; cfg_par_odd = odd; cfg_one_stop = one;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rx(input int nb, output logic [11:0] bits, output bit seen);
    int guard = 0;
    bits = '1;
    seen = 1'b0;
    while (txd !== 1'b0 && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    if (txd !== 1'b0) return;
    seen = 1'b1;
    repeat (8*tp) @(negedge clk);
    bits[0] = txd;
    for (int k = 1; k < nb; k++) begin
      repeat (16*tp) @(negedge clk);
      bits[k] = txd;
    end
  endtask

  task automatic send_one(input string req, input logic [7:0] d);
    logic [11:0] got, exp;
    bit seen;
    int nb;
    nb  = exp_nb(cfg_len, cfg_par_off, cfg_one_stop);
    exp = exp_bits(d, cfg_len, cfg_par_off, cfg_par_odd);
    wr(d);
    chk(!buf_empty || tx_busy, "R6", "write leaves block busy", tx_busy, 1);
    rx(nb, got, seen);
    chk(seen && got == exp, req, "frame bits", got, exp);
    repeat (7) @(negedge clk);
    chk(tx_busy === 1'b1, "R7", "busy before last stop ends", tx_busy, 1);
    @(negedge clk);
    chk(tx_busy === 1'b0 && txd === 1'b1, "R3", "busy falls after stop bits", tx_busy, 0);
  endtask

  task automatic t_reset;
    chk(txd === 1'b1, "R9", "reset txd", txd, 1);
    chk(buf_empty === 1'b1 && buf_full === 1'b0, "R4", "reset flags",
        {buf_empty, buf_full}, 2);
    chk(tx_busy === 1'b0, "R7", "reset busy", tx_busy, 0);
    chk(irq === 1'b0, "R8", "reset irq with enable low", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq === 1'b1, "R8", "irq follows empty when enabled", irq, 1);
    chk(buf_empty === 1'b1, "R6", "empty after reset", buf_empty, 1);
  endtask

  task automatic t_lengths;
    for (int c = 0; c < 4; c++) begin
      set_cfg(2'(c), 1'b0, 1'b0, 1'b0);
      send_one("R1", 8'hA5 ^ 8'(c * 8'h3C));
    end
  endtask

  task automatic t_parity;
    set_cfg(2'd1, 1'b0, 1'b1, 1'b1);
    send_one("R2", 8'hD3);
    set_cfg(2'd1, 1'b0, 1'b0, 1'b1);
    send_one("R2", 8'hD3);
    set_cfg(2'd0, 1'b1, 1'b1, 1'b1);
    send_one("R2", 8'h6E);
  endtask

  task automatic t_stops;
    set_cfg(2'd3, 1'b1, 1'b0, 1'b1);
    send_one("R3", 8'h15);
    set_cfg(2'd3, 1'b1, 1'b0, 1'b0);
    send_one("R3", 8'h15);
  endtask

  task automatic t_burst;
    logic [7:0] bytes [6] = '{8'h11, 8'h82, 8'h3C, 8'hF0, 8'h5A, 8'hEE};
    set_cfg(2'd0, 1'b1, 1'b0, 1'b1);
    fork
      begin
        for (int i = 0; i < 6; i++) begin
          @(negedge clk);
          wr_en = 1'b1; wr_data = bytes[i];
          if (i == 4) chk(buf_full === 1'b0, "R4", "not full at three", buf_full, 0);
        end
        @(negedge clk);
        wr_en = 1'b0;
        chk(buf_full === 1'b1 && buf_empty === 1'b0, "R4", "full at four",
            {buf_full, buf_empty}, 2);
        chk(irq === 1'b0, "R8", "no irq while bytes wait", irq, 0);
      end
      begin
        for (int f = 0; f < 5; f++) begin
          logic [11:0] got;
          bit seen;
          rx(10, got, seen);
          chk(seen && got == exp_bits(bytes[f], 2'd0, 1'b1, 1'b0), "R10",
              "burst order", got[8:1], bytes[f]);
          if (f == 4) begin
            chk(buf_empty === 1'b1 && tx_busy === 1'b1, "R6",
                "empty while last byte shifts", {buf_empty, tx_busy}, 3);
            chk(irq === 1'b1, "R8", "irq on drained buffer", irq, 1);
          end
        end
      end
    join
    repeat (20) @(negedge clk);
    chk(tx_busy === 1'b0, "R7", "idle after burst", tx_busy, 0);
    begin
      bit low = 1'b0;
      repeat (400) begin
        @(negedge clk);
        if (txd !== 1'b1) low = 1'b1;
      end
      chk(!low, "R5", "dropped byte never sent", low, 0);
    end
    irq_en = 1'b0;
    @(negedge clk);
    chk(irq === 1'b0, "R8", "irq masked", irq, 0);
  endtask

  task automatic t_slow_tick;
    logic [11:0] got;
    bit seen;
    tp = 3;
    set_cfg(2'd2, 1'b0, 1'b1, 1'b0);
    wr(8'h2B);
    rx(exp_nb(2'd2, 1'b0, 1'b0), got, seen);
    chk(seen && got == exp_bits(8'h2B, 2'd2, 1'b0, 1'b1), "R9",
        "frame at one tick per 3 clocks", got, exp_bits(8'h2B, 2'd2, 1'b0, 1'b1));
    repeat (40*tp) @(negedge clk);
    chk(tx_busy === 1'b0 && txd === 1'b1, "R9", "idle high after slow frame",
        {tx_busy, txd}, 1);
    tp = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_parity();
    t_stops();
    t_burst();
    t_slow_tick();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule